// File: doc/BRIEF.md
# Press-Duration Button Classifier

This block watches a single push button on a slow tick clock and measures how many ticks each press lasts. When the button is let go, it sorts the press into one of three duration bands and raises a sticky flag for that band. The bands are set by three ordered thresholds, `LONG_TICKS` > `MID_TICKS` > `SHORT_TICKS`. A power-control sequencer can use one instance on its power button, where a long hold means switch off and a medium hold means switch on. It can use a second instance on its reset button.

The raw button goes through a synchronizer before it is measured. A parameter chooses which input level counts as pressed. The pressed-time counter saturates, so a button held for any length of time still lands in the long band. A clear input empties all flags, and while it is held it also keeps the counter at zero.

Top module: `press_classifier`

## Requirements
- R1: The raw button passes through a two-stage synchronizer. The measured duration equals the number of clock edges at which the raw input was sampled pressed. The flag for a press appears after the third rising edge that samples the raw input released, and not before.
- R2: An input level equal to the parameter `PRESS_LEVEL` counts as pressed, and the other level counts as released. The default is 0, which makes the button low-active. A button that stays at the released level sets no flag.
- R3: The duration counter saturates at `LONG_TICKS`+1. A press of any length, including one far longer than the counter width could hold, is classed as long.
- R4: A press whose duration is greater than `LONG_TICKS` sets `flag_long`. The thresholds must satisfy `LONG_TICKS` > `MID_TICKS` > `SHORT_TICKS` > 0.
- R5: A press whose duration is greater than `MID_TICKS` and at most `LONG_TICKS` sets `flag_mid`.
- R6: A press whose duration is greater than `SHORT_TICKS` and at most `MID_TICKS` sets `flag_short`.
- R7: A press whose duration is at most `SHORT_TICKS` sets no flag. Each release sets at most one flag.
- R8: Flags are sticky. A set flag stays set through later presses, and flags from several presses accumulate until a clear arrives.
- R9: While `flag_clr` is high, all flags go to zero on the next edge, no flag can be set, and the duration counter is held at zero. Pressed time during the clear is therefore not counted.
- R10: When `rst_n` is sampled low, the flags and the counter go to zero and the synchronizer goes to the released level. The reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow tick clock, for example 1 kHz |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_raw | input | 1 | Asynchronous button level |
| flag_clr | input | 1 | Clears all flags and holds the counter at zero while high |
| flag_long | output | 1 | Sticky flag: press longer than `LONG_TICKS` |
| flag_mid | output | 1 | Sticky flag: press in the band (`MID_TICKS`, `LONG_TICKS`] |
| flag_short | output | 1 | Sticky flag: press in the band (`SHORT_TICKS`, `MID_TICKS`] |

## Verification
The assertions check on every cycle the properties that hold regardless of stimulus:
- the counter never passes its saturation value;
- a clear empties the flags and zeroes the counter on the next edge;
- no flag falls without a clear;
- new flag bits appear only on a release, and at most one at a time;
- a recognised press always traces back to a raw pressed sample two edges earlier.

Only the bench scenarios can show that a given duration lands in the correct band. They do this at each threshold and one tick past it. They also show that pressed time under a clear is excluded from the measurement, and that the opposite polarity classifies the same way.

// File: rtl/pc_pkg.sv
// Package: shared encodings for the press classifier.
// Assumes: thresholds are positive and strictly ordered long > mid > short.
package pc_pkg;

    // Duration band a completed press falls into.
    typedef enum logic [1:0] {
        BAND_NONE  = 2'd0,
        BAND_SHORT = 2'd1,
        BAND_MID   = 2'd2,
        BAND_LONG  = 2'd3
    } press_band_e;

    // Bit positions of the flags inside the 3-bit flag vector.
    localparam int FB_SHORT = 0;
    localparam int FB_MID   = 1;
    localparam int FB_LONG  = 2;
    localparam int NFLAGS   = 3;

    // Sort a measured duration into a band; upper bounds are inclusive.
    function automatic press_band_e band_of(input int dur, input int t_long,
                                            input int t_mid, input int t_short);
        if (dur > t_long)       return BAND_LONG;
        else if (dur > t_mid)   return BAND_MID;
        else if (dur > t_short) return BAND_SHORT;
        else                    return BAND_NONE;
    endfunction

endpackage

// File: rtl/pc_sync.sv
// Module: pc_sync
// Multi-stage synchronizer for one asynchronous level.
// Assumes: the input is a slow level; every stage resets to RST_VAL.
module pc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stg_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[0] <= RST_VAL;
                else        stg_q[0] <= d_i;
            end
        end else begin : g_next
            // Later stages resolve metastability of the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[i] <= RST_VAL;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pc_duration.sv
// Module: pc_duration
// Counts ticks of the synchronized pressed level, saturating at CAP,
// and flags the first released tick after a counted press.
// Assumes: pressed_i is already synchronous to clk.
module pc_duration #(
    parameter int LONG_TICKS = 40,
    localparam int CAP = LONG_TICKS + 1,
    localparam int CW  = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pressed_i,
    input  logic          clr_i,
    output logic [CW-1:0] dur_o,
    output logic          release_o
);

    logic [CW-1:0] cnt_q;

    // Pressed-time counter: held at zero by clear, reset on release.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (clr_i)                   cnt_q <= '0;
        else if (!pressed_i)              cnt_q <= '0;
        else if (cnt_q < CW'(CAP))        cnt_q <= cnt_q + 1'b1;
    end

    // A release is the first released tick while a count is pending.
    assign release_o = !pressed_i && (cnt_q != '0);
    assign dur_o     = cnt_q;

    // R3: the counter never runs past its cap.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CAP));

    // R9: a clear leaves the counter at zero on the next edge.
    a_r9_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/pc_flags.sv
// Module: pc_flags
// Classifies a finished press and ORs its band into sticky flags.
// Assumes: release_i lasts one cycle and dur_i is valid during it.
module pc_flags
    import pc_pkg::*;
#(
    parameter int LONG_TICKS  = 40,
    parameter int MID_TICKS   = 20,
    parameter int SHORT_TICKS = 5,
    parameter int CW          = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     dur_i,
    input  logic              release_i,
    input  logic              clr_i,
    output logic [NFLAGS-1:0] flags_o
);

    logic [NFLAGS-1:0] flags_q;
    logic [NFLAGS-1:0] hit;
    press_band_e       band;

    // Decode the band of the press that is ending this cycle.
    always_comb begin
        band = band_of(int'(dur_i), LONG_TICKS, MID_TICKS, SHORT_TICKS);
        hit  = '0;
        case (band)
            BAND_LONG:  hit[FB_LONG]  = 1'b1;
            BAND_MID:   hit[FB_MID]   = 1'b1;
            BAND_SHORT: hit[FB_SHORT] = 1'b1;
            default:    hit           = '0;
        endcase
    end

    // Sticky flag register; clear has priority over a release.
    always_ff @(posedge clk) begin
        if (!rst_n)         flags_q <= '0;
        else if (clr_i)     flags_q <= '0;
        else if (release_i) flags_q <= flags_q | hit;
    end

    assign flags_o = flags_q;

    // R9: a clear empties every flag on the next edge.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flags_q == '0));

    // R8: without a clear no flag falls.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R7: new flag bits appear only on a release, at most one at a time.
    a_r7_only_release: assert property (@(posedge clk) disable iff (!rst_n)
        !release_i |=> ((flags_q & ~$past(flags_q)) == '0));
    a_r7_one_band: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags_q & ~$past(flags_q)) <= 1);

endmodule

// File: rtl/press_classifier.sv
// Module: press_classifier (top)
// Synchronizes one button, measures each press and raises a sticky flag
// for the duration band the press falls into on release.
// Assumes: clk is a slow tick; LONG_TICKS > MID_TICKS > SHORT_TICKS > 0.
module press_classifier
    import pc_pkg::*;
#(
    parameter int   LONG_TICKS  = 40,
    parameter int   MID_TICKS   = 20,
    parameter int   SHORT_TICKS = 5,
    parameter logic PRESS_LEVEL = 1'b0,
    parameter int   SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    input  logic flag_clr,
    output logic flag_long,
    output logic flag_mid,
    output logic flag_short
);

    localparam int CW = $clog2(LONG_TICKS + 2);

    logic              btn_s;
    logic              pressed_s;
    logic [CW-1:0]     dur;
    logic              rel;
    logic [NFLAGS-1:0] flags;

    pc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(~PRESS_LEVEL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (btn_raw),
        .q_o   (btn_s)
    );

    // Map the synchronized level onto pressed/released.
    assign pressed_s = (btn_s == PRESS_LEVEL);

    pc_duration #(.LONG_TICKS(LONG_TICKS)) u_dur (
        .clk       (clk),
        .rst_n     (rst_n),
        .pressed_i (pressed_s),
        .clr_i     (flag_clr),
        .dur_o     (dur),
        .release_o (rel)
    );

    pc_flags #(
        .LONG_TICKS  (LONG_TICKS),
        .MID_TICKS   (MID_TICKS),
        .SHORT_TICKS (SHORT_TICKS),
        .CW          (CW)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .dur_i     (dur),
        .release_i (rel),
        .clr_i     (flag_clr),
        .flags_o   (flags)
    );

    assign flag_long  = flags[FB_LONG];
    assign flag_mid   = flags[FB_MID];
    assign flag_short = flags[FB_SHORT];

    // R4: threshold ordering is a precondition of the band decode.
    initial begin
        a_r4_order: assert (LONG_TICKS > MID_TICKS && MID_TICKS > SHORT_TICKS
                            && SHORT_TICKS > 0);
    end

    // R1: a recognised press traces back to a raw pressed sample two edges earlier.
    a_r1_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pressed_s) |-> $past(btn_raw == PRESS_LEVEL, 2));

endmodule

// File: tb/test_press_classifier.sv
// Bench for press_classifier: vector table walk, then directed cases.
module test_press_classifier;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    localparam int VDUR [NV] = '{3, 5, 6, 20, 21, 40, 41, 100, 1};
    // expected {long, mid, short}
    localparam logic [2:0] VEXP [NV] = '{3'b000, 3'b000, 3'b001, 3'b001,
                                         3'b010, 3'b010, 3'b100, 3'b100, 3'b000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn = 1'b1;
    logic btn_hi = 1'b0;
    logic clr = 1'b0;
    logic fl, fm, fs, hl, hm, hs;
    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    press_classifier i_press_classifier (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn), .flag_clr(clr),
        .flag_long(fl), .flag_mid(fm), .flag_short(fs));

    press_classifier #(.PRESS_LEVEL(1'b1)) i_press_classifier_hi (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn_hi), .flag_clr(clr),
        .flag_long(hl), .flag_mid(hm), .flag_short(hs));

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: flags=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulse();
        clr = 1'b1; ticks(1); clr = 1'b0; ticks(1);
    endtask

    // Hold the low-active button pressed for n sampling edges, then let go.
    task automatic press_lo(input int n);
        btn = 1'b0; ticks(n); btn = 1'b1; ticks(6);
    endtask

    initial begin
        ticks(3);
        check("R10 reset", {fl, fm, fs}, 3'b000);
        rst_n = 1'b1;
        ticks(2);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            clear_pulse();
            press_lo(VDUR[i]);
            tag = VEXP[i][2] ? "R4 long" : VEXP[i][1] ? "R5 mid" :
                  VEXP[i][0] ? "R6 short" : "R7 none";
            check(tag, {fl, fm, fs}, VEXP[i]);
        end

        // R3: press far beyond the counter range still classes as long
        clear_pulse();
        press_lo(200);
        check("R3 saturate", {fl, fm, fs}, 3'b100);

        // R1: flag appears exactly on the third edge after release
        clear_pulse();
        btn = 1'b0; ticks(30); btn = 1'b1;
        ticks(1); check("R1 edge+1", {fl, fm, fs}, 3'b000);
        ticks(1); check("R1 edge+2", {fl, fm, fs}, 3'b000);
        ticks(1); check("R1 edge+3", {fl, fm, fs}, 3'b010);

        // R8: flags accumulate across presses
        clear_pulse();
        press_lo(10);
        press_lo(30);
        check("R8 sticky", {fl, fm, fs}, 3'b011);
        press_lo(2);
        check("R8 hold", {fl, fm, fs}, 3'b011);

        // R9: clear empties flags
        clear_pulse();
        check("R9 clear", {fl, fm, fs}, 3'b000);

        // R9: press entirely under clear sets nothing
        clr = 1'b1;
        press_lo(50);
        clr = 1'b0; ticks(2);
        check("R9 held press", {fl, fm, fs}, 3'b000);

        // R9: first 20 pressed samples under clear are not counted (45 -> ~27, mid)
        clr = 1'b1; btn = 1'b0; ticks(20);
        clr = 1'b0; ticks(25);
        btn = 1'b1; ticks(6);
        check("R9 partial", {fl, fm, fs}, 3'b010);

        // R2: high-active instance classifies the same; idle high on low-active sets nothing
        clear_pulse();
        btn_hi = 1'b1; ticks(25); btn_hi = 1'b0; ticks(6);
        check("R2 active high", {hl, hm, hs}, 3'b010);
        check("R2 idle level", {fl, fm, fs}, 3'b000);

        // R10: reset clears set flags and abandons a press in progress
        press_lo(50);
        btn = 1'b0; ticks(10);
        rst_n = 1'b0; ticks(2);
        check("R10 reset flags", {fl, fm, fs}, 3'b000);
        rst_n = 1'b1; btn = 1'b1; ticks(6);
        check("R10 after reset", {fl, fm, fs}, 3'b000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule